// File: doc/BRIEF.md
# Scalar Register Mover with Indexed Addressing

This block holds a bank of 104 scalar registers, each 32 bits wide, plus a separate 32-bit index register called M0. It executes move instructions only. A plain move copies a value into a register. A conditional move does the same, but only when the incoming scalar condition bit is set. Two relative moves add M0 to either the source register number or the destination register number. One index-set instruction replaces the low byte of M0. Each move has a single-register form and a register-pair form. In the pair form the low word goes to the even register and the high word to the register above it. The source is either a register or an immediate value carried with the instruction.

Each instruction is presented on `op_valid` and is captured into a one-entry pending stage. The block is a two-state machine. State ST_IDLE moves to ST_COMMIT on the transition "issue", which happens when `op_valid` is high. ST_COMMIT stays in ST_COMMIT on "chain", when another instruction is valid, and returns to ST_IDLE on "drain" otherwise. While in ST_COMMIT, the pending instruction reads its source and M0 from the current state and writes its result at the next clock edge. An instruction that names a misaligned pair, or an index beyond the last register, raises `range_err` for one cycle and changes nothing. A combinational read port and an M0 output let the surrounding logic observe the state. M0 can also be loaded directly.

Top module: `sreg_mover`

## Requirements
- R1: After reset all 104 registers read as zero, `m0_value` is zero and `range_err` is low.
- R2: Opcode 0x00 copies a 32-bit source into the destination register. Opcode 0x01 copies a 64-bit source into the pair (dst, dst+1), with the low word in dst. When `src_imm` is 1 the source is `imm_lo` for the 32-bit form and {`imm_hi`,`imm_lo`} for the pair form. When `src_imm` is 0 the source is register src, or the pair (src, src+1).
- R3: Opcodes 0x02 (32-bit) and 0x03 (pair) behave like R2 when `scc` is 1. When `scc` is 0 they leave every register unchanged.
- R4: Opcodes 0x2A (32-bit) and 0x2B (pair) read the source at register number src+M0, or the pair (src+M0, src+M0+1), and write it to dst. For these two opcodes `src_imm` is ignored.
- R5: Opcodes 0x2C (32-bit) and 0x2D (pair) write the source, register or immediate, to register dst+M0, or to the pair (dst+M0, dst+M0+1).
- R6: Opcode 0x32 sets M0[7:0] to the low 8 bits of the source, register or immediate. M0[31:8] is kept, and no register is written.
- R7: A pulse on `m0_wr` loads `m0_wdata` into M0 at the clock edge. If an 0x32 instruction commits at the same edge, the 0x32 result wins.
- R8: In every pair form, a first register number that is odd, after M0 is added where the opcode calls for it, raises `range_err` for one cycle and suppresses all writes of that instruction.
- R9: A source or destination register number above 103, after M0 is added with the full 32-bit value, raises `range_err` and suppresses the write. For the pair forms this also applies when the second register is above 103. `rd_sel` above 103 reads zero.
- R10: An instruction valid at clock edge k writes at edge k+1, so `rd_data` shows the new value after that edge. Instructions on consecutive cycles see each other's results in program order.
- R11: Any other opcode writes nothing, leaves M0 unchanged and does not raise `range_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Instruction present this cycle |
| op_code | input | 6 | Instruction opcode |
| src_num | input | 7 | Source register number |
| dst_num | input | 7 | Destination register number |
| src_imm | input | 1 | Use the immediate as source |
| imm_lo | input | 32 | Immediate, low word |
| imm_hi | input | 32 | Immediate, high word (pair forms) |
| scc | input | 1 | Condition bit for conditional moves |
| m0_wr | input | 1 | Direct M0 load strobe |
| m0_wdata | input | 32 | Direct M0 load value |
| rd_sel | input | 7 | Read port register number |
| rd_data | output | 32 | Read port data |
| m0_value | output | 32 | Current M0 |
| range_err | output | 1 | Misaligned or out-of-range access, one-cycle pulse |

## Verification
A wrong M0 value stays hidden until a relative move uses it. The next such move then lands in, or reads from, the wrong register, and the error shows on `rd_data` or as a false `range_err` one edge after the commit. A broken pair lane or a broken write suppression shows on the read port in the cycle after the commit. The bench therefore checks the destination registers and M0 right after every instruction. It also sweeps the whole register file at fixed points, so that a stray write to an unrelated register cannot go unseen.

// File: rtl/smv_pkg.sv
package smv_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_MOV_W   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_MOV_D   = 6'h01;
    localparam logic [OPC_W-1:0] OPC_CMOV_W  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_CMOV_D  = 6'h03;
    localparam logic [OPC_W-1:0] OPC_RSRC_W  = 6'h2A;
    localparam logic [OPC_W-1:0] OPC_RSRC_D  = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_RDST_W  = 6'h2C;
    localparam logic [OPC_W-1:0] OPC_RDST_D  = 6'h2D;
    localparam logic [OPC_W-1:0] OPC_IDXSET  = 6'h32;

    typedef enum logic [2:0] {
        CLS_NOP,
        CLS_MOV,
        CLS_CMOV,
        CLS_RELSRC,
        CLS_RELDST,
        CLS_IDXSET
    } mv_cls_e;

    typedef struct packed {
        mv_cls_e cls;
        logic    wide;
    } mv_dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_COMMIT
    } mv_state_e;

endpackage

// File: rtl/smv_decode.sv
module smv_decode
    import smv_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output mv_dec_t          dec
);

    always_comb begin
        dec.cls  = CLS_NOP;
        dec.wide = 1'b0;
        unique case (opcode)
            OPC_MOV_W:  begin dec.cls = CLS_MOV;    dec.wide = 1'b0; end
            OPC_MOV_D:  begin dec.cls = CLS_MOV;    dec.wide = 1'b1; end
            OPC_CMOV_W: begin dec.cls = CLS_CMOV;   dec.wide = 1'b0; end
            OPC_CMOV_D: begin dec.cls = CLS_CMOV;   dec.wide = 1'b1; end
            OPC_RSRC_W: begin dec.cls = CLS_RELSRC; dec.wide = 1'b0; end
            OPC_RSRC_D: begin dec.cls = CLS_RELSRC; dec.wide = 1'b1; end
            OPC_RDST_W: begin dec.cls = CLS_RELDST; dec.wide = 1'b0; end
            OPC_RDST_D: begin dec.cls = CLS_RELDST; dec.wide = 1'b1; end
            OPC_IDXSET: begin dec.cls = CLS_IDXSET; dec.wide = 1'b0; end
            default:    begin dec.cls = CLS_NOP;    dec.wide = 1'b0; end
        endcase
    end

endmodule

// File: rtl/smv_addr_check.sv
module smv_addr_check #(
    parameter int NUM_REGS = 104,
    parameter int DATA_W   = 32,
    parameter int RN_W     = $clog2(NUM_REGS)
) (
    input  logic [RN_W-1:0]   base,
    input  logic [DATA_W-1:0] offset,
    input  logic              rel,
    input  logic              wide,
    output logic [RN_W-1:0]   addr,
    output logic              bad
);

    localparam int SUM_W = DATA_W + 2;

    logic [SUM_W-1:0] first_idx;
    logic [SUM_W-1:0] last_idx;

    always_comb begin
        first_idx = SUM_W'(base) + (rel ? SUM_W'(offset) : '0);
        last_idx  = first_idx + SUM_W'(wide);
        bad       = (last_idx > SUM_W'(NUM_REGS - 1)) || (wide && first_idx[0]);
        addr      = first_idx[RN_W-1:0];
    end

endmodule

// File: rtl/smv_regfile.sv
module smv_regfile #(
    parameter int NUM_REGS = 104,
    parameter int DATA_W   = 32,
    parameter int RN_W     = $clog2(NUM_REGS),
    parameter int NRD      = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_lo,
    input  logic [RN_W-1:0]            wa_lo,
    input  logic [DATA_W-1:0]          wd_lo,
    input  logic                       we_hi,
    input  logic [RN_W-1:0]            wa_hi,
    input  logic [DATA_W-1:0]          wd_hi,
    input  logic [NRD-1:0][RN_W-1:0]   ra,
    output logic [NRD-1:0][DATA_W-1:0] rd
);

    logic [DATA_W-1:0] mem_q [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (we_lo) mem_q[wa_lo] <= wd_lo;
            if (we_hi) mem_q[wa_hi] <= wd_hi;
        end
    end

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            assign rd[g] = (ra[g] < RN_W'(NUM_REGS)) ? mem_q[ra[g]] : '0;
        end
    endgenerate

    // R9
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo |-> (wa_lo < RN_W'(NUM_REGS))) and (we_hi |-> (wa_hi < RN_W'(NUM_REGS))));

    // R2
    pair_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi |-> (we_lo && (wa_hi == wa_lo + RN_W'(1)) && !wa_lo[0]));

endmodule

// File: rtl/sreg_mover.sv
module sreg_mover
    import smv_pkg::*;
#(
    parameter int NUM_REGS = 104,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 8,
    localparam int RN_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [RN_W-1:0]   src_num,
    input  logic [RN_W-1:0]   dst_num,
    input  logic              src_imm,
    input  logic [DATA_W-1:0] imm_lo,
    input  logic [DATA_W-1:0] imm_hi,
    input  logic              scc,
    input  logic              m0_wr,
    input  logic [DATA_W-1:0] m0_wdata,
    input  logic [RN_W-1:0]   rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] m0_value,
    output logic              range_err
);

    localparam int NRD = 3;

    mv_state_e state_q, state_n;

    mv_dec_t             dec_in;
    mv_dec_t             dec_q;
    logic [RN_W-1:0]     src_q, dst_q;
    logic [2*DATA_W-1:0] imm_q;
    logic                imm_sel_q;
    logic                scc_q;

    logic [DATA_W-1:0]   m0_q;
    logic                err_q;

    logic [RN_W-1:0]     src_addr, dst_addr;
    logic                src_bad, dst_bad;
    logic                src_rel, dst_rel;

    logic                commit, take_imm, known;
    logic                src_chk_en, dst_chk_en, bad;
    logic [2*DATA_W-1:0] src_val;
    logic                we_lo, we_hi, idx_fire, err_n;

    logic [NRD-1:0][RN_W-1:0]   rf_ra;
    logic [NRD-1:0][DATA_W-1:0] rf_rd;

    smv_decode u_decode (
        .opcode (op_code),
        .dec    (dec_in)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   state_n = op_valid ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_n = op_valid ? ST_COMMIT : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register and pending stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            dec_q     <= '{cls: CLS_NOP, wide: 1'b0};
            src_q     <= '0;
            dst_q     <= '0;
            imm_q     <= '0;
            imm_sel_q <= 1'b0;
            scc_q     <= 1'b0;
        end else begin
            state_q <= state_n;
            if (op_valid) begin
                dec_q     <= dec_in;
                src_q     <= src_num;
                dst_q     <= dst_num;
                imm_q     <= {imm_hi, imm_lo};
                imm_sel_q <= src_imm;
                scc_q     <= scc;
            end
        end
    end

    assign src_rel = (dec_q.cls == CLS_RELSRC);
    assign dst_rel = (dec_q.cls == CLS_RELDST);

    smv_addr_check #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .RN_W     (RN_W)
    ) u_src_chk (
        .base   (src_q),
        .offset (m0_q),
        .rel    (src_rel),
        .wide   (dec_q.wide),
        .addr   (src_addr),
        .bad    (src_bad)
    );

    smv_addr_check #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .RN_W     (RN_W)
    ) u_dst_chk (
        .base   (dst_q),
        .offset (m0_q),
        .rel    (dst_rel),
        .wide   (dec_q.wide),
        .addr   (dst_addr),
        .bad    (dst_bad)
    );

    // output / commit decisions for the current state
    always_comb begin
        commit     = (state_q == ST_COMMIT);
        known      = (dec_q.cls != CLS_NOP);
        take_imm   = imm_sel_q && !src_rel;
        src_chk_en = known && !take_imm;
        dst_chk_en = known && (dec_q.cls != CLS_IDXSET);
        bad        = (src_chk_en && src_bad) || (dst_chk_en && dst_bad);
        src_val    = take_imm ? imm_q : {rf_rd[1], rf_rd[0]};
        we_lo      = commit && !bad && dst_chk_en && ((dec_q.cls != CLS_CMOV) || scc_q);
        we_hi      = we_lo && dec_q.wide;
        idx_fire   = commit && !bad && (dec_q.cls == CLS_IDXSET);
        err_n      = commit && bad;
    end

    assign rf_ra[0] = src_addr;
    assign rf_ra[1] = src_addr + RN_W'(1);
    assign rf_ra[2] = rd_sel;

    smv_regfile #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .RN_W     (RN_W),
        .NRD      (NRD)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we_lo (we_lo),
        .wa_lo (dst_addr),
        .wd_lo (src_val[DATA_W-1:0]),
        .we_hi (we_hi),
        .wa_hi (dst_addr + RN_W'(1)),
        .wd_hi (src_val[2*DATA_W-1:DATA_W]),
        .ra    (rf_ra),
        .rd    (rf_rd)
    );

    // index register and error pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m0_q  <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= err_n;
            if (idx_fire) begin
                m0_q[IDX_W-1:0] <= src_val[IDX_W-1:0];
            end else if (m0_wr) begin
                m0_q <= m0_wdata;
            end
        end
    end

    assign rd_data   = rf_rd[2];
    assign m0_value  = m0_q;
    assign range_err = err_q;

    // R10
    issue_to_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (state_q == ST_COMMIT));

    // R9
    err_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> $past(state_q == ST_COMMIT));

    // R6
    idx_upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_fire |=> (m0_q[DATA_W-1:IDX_W] == $past(m0_q[DATA_W-1:IDX_W])));

    // R11
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !known) |=> (!range_err && $stable(m0_q)));

endmodule

// File: tb/sreg_mover_tb.sv
module sreg_mover_tb;
    import smv_pkg::*;

    localparam int NR = 104;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [5:0]  op_code = '0;
    logic [6:0]  src_num = '0;
    logic [6:0]  dst_num = '0;
    logic        src_imm = 1'b0;
    logic [31:0] imm_lo = '0;
    logic [31:0] imm_hi = '0;
    logic        scc = 1'b0;
    logic        m0_wr = 1'b0;
    logic [31:0] m0_wdata = '0;
    logic [6:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [31:0] m0_value;
    logic        range_err;

    always #10 clk = ~clk;

    sreg_mover u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .src_num   (src_num),
        .dst_num   (dst_num),
        .src_imm   (src_imm),
        .imm_lo    (imm_lo),
        .imm_hi    (imm_hi),
        .scc       (scc),
        .m0_wr     (m0_wr),
        .m0_wdata  (m0_wdata),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .m0_value  (m0_value),
        .range_err (range_err)
    );

    logic [31:0] mdl_rf [NR];
    logic [31:0] mdl_m0;
    bit          exp_err;
    longint      last_da;
    int          n_chk = 0;
    int          n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        rd_sel = 7'(a);
        #1;
        v = rd_data;
    endtask

    function automatic bit span_bad(longint a, bit w);
        return ((a + (w ? 1 : 0)) > NR - 1) || (w && ((a % 2) != 0));
    endfunction

    function automatic string tag_of(logic [5:0] op);
        case (op)
            6'h00, 6'h01: return "R2";
            6'h02, 6'h03: return "R3";
            6'h2A, 6'h2B: return "R4";
            6'h2C, 6'h2D: return "R5";
            6'h32:        return "R6";
            default:      return "R11";
        endcase
    endfunction

    // drive one instruction at a falling edge and update the model
    task automatic drive_op(input logic [5:0] op, input int s, input int d, input bit imm,
                            input logic [63:0] iv, input bit c);
        bit known, wide, rels, reld, idx, cmov, simm, err;
        longint sa, da;
        logic [63:0] val;
        known = (op == 6'h00) || (op == 6'h01) || (op == 6'h02) || (op == 6'h03) ||
                (op == 6'h2A) || (op == 6'h2B) || (op == 6'h2C) || (op == 6'h2D) || (op == 6'h32);
        wide  = known && op[0];
        rels  = (op == 6'h2A) || (op == 6'h2B);
        reld  = (op == 6'h2C) || (op == 6'h2D);
        idx   = (op == 6'h32);
        cmov  = (op == 6'h02) || (op == 6'h03);
        simm  = imm && !rels;
        sa    = longint'(s) + (rels ? longint'(mdl_m0) : 64'sd0);
        da    = longint'(d) + (reld ? longint'(mdl_m0) : 64'sd0);
        err   = known && ((!simm && span_bad(sa, wide)) || (!idx && span_bad(da, wide)));
        val   = 64'd0;
        if (simm) begin
            val = iv;
        end else if (!err && known) begin
            val[31:0] = mdl_rf[sa];
            if (wide) val[63:32] = mdl_rf[sa + 1];
        end
        if (known && !err) begin
            if (idx) mdl_m0[7:0] = val[7:0];
            else if (!cmov || c) begin
                mdl_rf[da] = val[31:0];
                if (wide) mdl_rf[da + 1] = val[63:32];
            end
        end
        exp_err = err;
        last_da = da;
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = op;
        src_num  = 7'(s);
        dst_num  = 7'(d);
        src_imm  = imm;
        imm_lo   = iv[31:0];
        imm_hi   = iv[63:32];
        scc      = c;
    endtask

    task automatic settle();
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_after(input string tag);
        logic [31:0] v;
        chk({tag, " err"}, {31'd0, range_err}, {31'd0, exp_err});
        chk({tag, " m0"}, m0_value, mdl_m0);
        if (last_da >= 0 && last_da < NR) begin
            rd(int'(last_da), v);
            chk({tag, " dst"}, v, mdl_rf[last_da]);
        end
        if (last_da + 1 >= 0 && last_da + 1 < NR) begin
            rd(int'(last_da + 1), v);
            chk({tag, " dst+1"}, v, mdl_rf[last_da + 1]);
        end
    endtask

    task automatic run_op(input logic [5:0] op, input int s, input int d, input bit imm,
                          input logic [63:0] iv, input bit c, input string tag);
        drive_op(op, s, d, imm, iv, c);
        settle();
        check_after(tag);
    endtask

    task automatic load_m0(input logic [31:0] v);
        @(negedge clk);
        m0_wr    = 1'b1;
        m0_wdata = v;
        mdl_m0   = v;
        @(negedge clk);
        m0_wr = 1'b0;
        chk("R7 load", m0_value, mdl_m0);
    endtask

    task automatic sweep(input string tag);
        logic [31:0] v;
        for (int i = 0; i < NR; i++) begin
            rd(i, v);
            chk(tag, v, mdl_rf[i]);
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int unsigned seed_r;
        logic [5:0] ops [10];
        seed_r = $urandom(32'd24680);
        ops = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h2A, 6'h2B, 6'h2C, 6'h2D, 6'h32, 6'h15};
        for (int i = 0; i < NR; i++) mdl_rf[i] = '0;
        mdl_m0 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 m0", m0_value, 32'd0);
        chk("R1 err", {31'd0, range_err}, 32'd0);
        sweep("R1 regs");

        // R2 plain moves
        run_op(6'h00, 0, 5, 1'b1, 64'h0000_0000_DEAD_BEEF, 1'b0, "R2 imm32");
        run_op(6'h01, 0, 10, 1'b1, 64'h1111_2222_3333_4444, 1'b0, "R2 imm64");
        run_op(6'h00, 5, 7, 1'b0, 64'd0, 1'b0, "R2 reg32");
        run_op(6'h01, 10, 40, 1'b0, 64'd0, 1'b0, "R2 reg64");

        // R3 conditional moves
        run_op(6'h02, 0, 7, 1'b1, 64'h0000_0000_0BAD_F00D, 1'b0, "R3 scc0");
        run_op(6'h02, 0, 7, 1'b1, 64'h0000_0000_600D_CAFE, 1'b1, "R3 scc1");
        run_op(6'h03, 0, 12, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, "R3 pair scc0");
        run_op(6'h03, 0, 12, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, "R3 pair scc1");

        // R4 relative source, src_imm ignored
        load_m0(32'd4);
        run_op(6'h2A, 1, 20, 1'b1, 64'h0000_0000_FFFF_FFFF, 1'b0, "R4 rel32");
        run_op(6'h2B, 6, 30, 1'b0, 64'd0, 1'b0, "R4 rel64");

        // R5 relative destination
        run_op(6'h2C, 0, 50, 1'b1, 64'h0000_0000_5555_AAAA, 1'b0, "R5 rel32");
        run_op(6'h2D, 10, 60, 1'b0, 64'd0, 1'b0, "R5 rel64");

        // R6 index byte update
        load_m0(32'h1234_5604);
        run_op(6'h32, 0, 0, 1'b1, 64'h0000_0000_ABCD_EF09, 1'b0, "R6 imm");
        chk("R6 value", m0_value, 32'h1234_5609);
        run_op(6'h32, 5, 0, 1'b0, 64'd0, 1'b0, "R6 reg");

        // R7 collision: commit of index set wins over load port
        load_m0(32'h0000_0000);
        drive_op(6'h32, 0, 0, 1'b1, 64'h0000_0000_0000_0033, 1'b0);
        @(negedge clk);
        op_valid = 1'b0;
        m0_wr    = 1'b1;
        m0_wdata = 32'h7777_7777;
        @(negedge clk);
        m0_wr = 1'b0;
        chk("R7 collision", m0_value, 32'h0000_0033);
        load_m0(32'd0);

        // R8 misaligned pairs
        run_op(6'h01, 0, 11, 1'b1, 64'h9999_9999_9999_9999, 1'b0, "R8 odd dst");
        run_op(6'h01, 13, 14, 1'b0, 64'd0, 1'b0, "R8 odd src");
        load_m0(32'd1);
        run_op(6'h2D, 0, 20, 1'b1, 64'h1234_1234_1234_1234, 1'b0, "R8 odd rel dst");

        // R9 range
        load_m0(32'd0);
        run_op(6'h00, 0, 104, 1'b1, 64'h0000_0000_0101_0101, 1'b0, "R9 dst 104");
        run_op(6'h01, 0, 102, 1'b1, 64'h0202_0202_0303_0303, 1'b0, "R9 pair top ok");
        run_op(6'h00, 110, 3, 1'b0, 64'd0, 1'b0, "R9 src 110");
        load_m0(32'hFFFF_FF80);
        run_op(6'h2A, 1, 2, 1'b0, 64'd0, 1'b0, "R9 huge m0");
        load_m0(32'd3);
        run_op(6'h2C, 0, 101, 1'b1, 64'h0000_0000_0404_0404, 1'b0, "R9 rel past end");
        rd(120, v);
        chk("R9 rd_sel high", v, 32'd0);
        load_m0(32'd0);

        // R11 unknown opcode
        run_op(6'h15, 0, 8, 1'b1, 64'h0000_0000_EEEE_EEEE, 1'b1, "R11 unknown");
        sweep("R11 regs");

        // R10 back-to-back dependency
        drive_op(6'h00, 0, 70, 1'b1, 64'h0000_0000_CAFE_0001, 1'b0);
        drive_op(6'h00, 70, 71, 1'b0, 64'd0, 1'b0);
        settle();
        check_after("R10 chain");
        rd(70, v);
        chk("R10 first", v, 32'hCAFE_0001);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [5:0] op;
            int s, d;
            bit imm, c;
            logic [63:0] iv;
            if ($urandom_range(0, 7) == 0) begin
                if ($urandom_range(0, 15) == 0) load_m0(32'hFFFF_FF80);
                else load_m0(32'($urandom_range(0, 24)));
            end
            op  = ops[$urandom_range(0, 9)];
            s   = $urandom_range(0, 107);
            d   = $urandom_range(0, 107);
            if ($urandom_range(0, 9) < 7) begin
                s = s & ~1;
                d = d & ~1;
            end
            imm = $urandom_range(0, 1) == 1;
            c   = $urandom_range(0, 1) == 1;
            iv  = {$urandom, $urandom};
            run_op(op, s, d, imm, iv, c, tag_of(op));
        end
        sweep("R10 final regs");

        finish_run();
    end

endmodule